// File: doc/BRIEF.md
# Tuning-Word Register Write Decoder

This block sits between a command-word source and a numerically controlled oscillator. Each 16-bit command word arrives with a one-cycle valid strobe. The block decodes the word into a write to one of five registers: a control register, two 28-bit frequency tuning registers and two 12-bit phase offset registers. The two top bits of the word pick the target. The frequency registers are wider than the 14 data bits that a single word carries, so the block assembles them in one of two ways, and a control bit picks the way.

In paired mode, a 28-bit load takes two consecutive words to the same frequency address. The low half comes first and waits in a staging register. Both halves reach the register together when the high half arrives. In split mode, each frequency word replaces one 14-bit half and leaves the other half as it was. A second control bit picks which half, so coarse and fine tuning can be done separately.

The outputs are the current contents of every register, plus the frequency-select and phase-select bits that steer the accumulator. All registered outputs change on the clock edge that samples the strobe.

Top module: `dds_reg_decoder`

## Requirements
- R1: After reset, every register output is zero and both select outputs are 0.
- R2: A strobed word with bits [15:14]=00 stores bits [13:0] in the control register. The freq_sel output follows control bit 11 and phase_sel follows control bit 10. Frequency and phase registers keep their values.
- R3: A strobed word with bits [15:14]=11 loads bits [11:0] into phase register 0 when bit 13 is 0, or into phase register 1 when bit 13 is 1. Bit 12 has no effect, and the other phase register keeps its value.
- R4: Bits [15:14]=01 address frequency register 0 and 10 address frequency register 1. Bits [13:0] carry the data.
- R5: With control bit 13 set (paired mode), the first word to a frequency address supplies bits [13:0] and the next word to the same address supplies bits [27:14]. Both halves are written together. The words 0x2000, 0x4000, 0x403F leave frequency register 0 at 0x00FC000.
- R6: In paired mode, a first half alone leaves both frequency registers unchanged.
- R7: With control bits 13 and 12 both 0, a frequency word replaces only bits [13:0] of its register. The words 0x0000, 0xBFFF set the low half of frequency register 1 to 0x3FFF and keep its high half.
- R8: With control bit 13 at 0 and bit 12 at 1, a frequency word replaces only bits [27:14]. The words 0x1000, 0x40FF set the high half of frequency register 0 to 0x00FF and keep its low half.
- R9: In paired mode, a control word or a phase word between the two halves discards the staged half. The next frequency word is then taken as a low half.
- R10: In paired mode, a frequency word to the other address while a half is staged discards the staged half. That word becomes the low half of its own address.
- R11: A word presented while the strobe is low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Strobe qualifying cmd_word for one cycle |
| cmd_word | input | 16 | Command word |
| ctrl_word | output | 14 | Control register contents |
| freq0 | output | 28 | Frequency register 0 |
| freq1 | output | 28 | Frequency register 1 |
| phase0 | output | 12 | Phase register 0 |
| phase1 | output | 12 | Phase register 1 |
| freq_sel | output | 1 | Frequency select toward the accumulator |
| phase_sel | output | 1 | Phase select toward the accumulator |

## Verification
The decoder is driven with paired loads whose two halves differ, so that a swapped or dropped half shows up. It is also driven with split loads into a register whose other half is already non-zero, which shows whether the half that should be kept is in fact kept. Interruptions by control, phase and other-address words are placed between two halves, and they separate correct cancellation from stale staging. Phase words with bit 12 set, and words held while the strobe is low, confirm that those inputs are ignored.

// File: rtl/dds_dec_pkg.sv
package dds_dec_pkg;

    localparam int CMD_W   = 16;
    localparam int HALF_W  = 14;
    localparam int FREQ_W  = 2 * HALF_W;
    localparam int PHASE_W = 12;
    localparam int CTRL_W  = 14;
    localparam int N_FREQ  = 2;
    localparam int N_PHASE = 2;

    // control bit positions (decoded by the loader and the select outputs)
    localparam int CB_PAIRED = 13;
    localparam int CB_MSB    = 12;
    localparam int CB_FSEL   = 11;
    localparam int CB_PSEL   = 10;

    typedef enum logic [1:0] {
        TGT_CTRL  = 2'b00,
        TGT_FREQ0 = 2'b01,
        TGT_FREQ1 = 2'b10,
        TGT_PHASE = 2'b11
    } tgt_e;

    typedef struct packed {
        logic                vld;
        tgt_e                tgt;
        logic                is_freq;
        logic                f_idx;
        logic                p_idx;
        logic [HALF_W-1:0]   half;
        logic [PHASE_W-1:0]  phase;
        logic [CTRL_W-1:0]   ctrl;
    } cmd_t;

endpackage

// File: rtl/dds_cmd_classify.sv
module dds_cmd_classify
    import dds_dec_pkg::*;
(
    input  logic             valid_i,
    input  logic [CMD_W-1:0] word_i,
    output cmd_t             cmd_o
);

    always_comb begin
        cmd_o         = '0;
        cmd_o.vld     = valid_i;
        cmd_o.tgt     = tgt_e'(word_i[CMD_W-1 -: 2]);
        cmd_o.is_freq = (cmd_o.tgt == TGT_FREQ0) || (cmd_o.tgt == TGT_FREQ1);
        cmd_o.f_idx   = (cmd_o.tgt == TGT_FREQ1);
        cmd_o.p_idx   = word_i[13];
        cmd_o.half    = word_i[HALF_W-1:0];
        cmd_o.phase   = word_i[PHASE_W-1:0];
        cmd_o.ctrl    = word_i[CTRL_W-1:0];
    end

endmodule

// File: rtl/dds_freq_loader.sv
module dds_freq_loader
    import dds_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd_i,
    input  logic              paired_i,
    input  logic              msb_i,
    output logic [FREQ_W-1:0] freq0_o,
    output logic [FREQ_W-1:0] freq1_o
);

    typedef struct packed {
        logic [N_FREQ-1:0][FREQ_W-1:0] freq;
        logic [HALF_W-1:0]             stage;
        logic                          pend;
        logic                          pend_idx;
    } fl_state_t;

    fl_state_t st_d, st_q;
    logic      completes;

    always_comb begin
        st_d      = st_q;
        completes = st_q.pend && (st_q.pend_idx == cmd_i.f_idx);
        if (cmd_i.vld) begin
            if (cmd_i.is_freq) begin
                if (paired_i) begin
                    if (completes) begin
                        st_d.freq[cmd_i.f_idx] = {cmd_i.half, st_q.stage};
                        st_d.pend              = 1'b0;
                    end else begin
                        st_d.stage    = cmd_i.half;
                        st_d.pend     = 1'b1;
                        st_d.pend_idx = cmd_i.f_idx;
                    end
                end else begin
                    st_d.pend = 1'b0;
                    if (msb_i) begin
                        st_d.freq[cmd_i.f_idx][FREQ_W-1:HALF_W] = cmd_i.half;
                    end else begin
                        st_d.freq[cmd_i.f_idx][HALF_W-1:0] = cmd_i.half;
                    end
                end
            end else begin
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign freq0_o = st_q.freq[0];
    assign freq1_o = st_q.freq[1];

    AST_NONFREQ_KEEPS_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.vld && !cmd_i.is_freq) |=> ($stable(freq0_o) && $stable(freq1_o))); // R2

    AST_FIRST_HALF_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.vld && cmd_i.is_freq && paired_i && !(st_q.pend && st_q.pend_idx == cmd_i.f_idx))
        |=> ($stable(freq0_o) && $stable(freq1_o))); // R6

    AST_MSB_WRITE_KEEPS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.vld && cmd_i.is_freq && !paired_i && msb_i && !cmd_i.f_idx)
        |=> (freq0_o[HALF_W-1:0] == $past(freq0_o[HALF_W-1:0]))); // R8

    AST_LSB_WRITE_KEEPS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.vld && cmd_i.is_freq && !paired_i && !msb_i && cmd_i.f_idx)
        |=> (freq1_o[FREQ_W-1:HALF_W] == $past(freq1_o[FREQ_W-1:HALF_W]))); // R7

endmodule

// File: rtl/dds_phase_bank.sv
module dds_phase_bank
    import dds_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_t               cmd_i,
    output logic [PHASE_W-1:0] phase0_o,
    output logic [PHASE_W-1:0] phase1_o
);

    typedef struct packed {
        logic [N_PHASE-1:0][PHASE_W-1:0] ph;
    } pb_state_t;

    pb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_i.vld && cmd_i.tgt == TGT_PHASE) begin
            st_d.ph[cmd_i.p_idx] = cmd_i.phase;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase0_o = st_q.ph[0];
    assign phase1_o = st_q.ph[1];

    AST_PHASE0_WRITE_KEEPS_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.vld && cmd_i.tgt == TGT_PHASE && !cmd_i.p_idx) |=> $stable(phase1_o)); // R3

    AST_PHASE1_WRITE_KEEPS_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.vld && cmd_i.tgt == TGT_PHASE && cmd_i.p_idx) |=> $stable(phase0_o)); // R3

endmodule

// File: rtl/dds_reg_decoder.sv
module dds_reg_decoder
    import dds_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [CMD_W-1:0]   cmd_word,
    output logic [CTRL_W-1:0]  ctrl_word,
    output logic [FREQ_W-1:0]  freq0,
    output logic [FREQ_W-1:0]  freq1,
    output logic [PHASE_W-1:0] phase0,
    output logic [PHASE_W-1:0] phase1,
    output logic               freq_sel,
    output logic               phase_sel
);

    cmd_t              cmd;
    logic [CTRL_W-1:0] ctrl_d, ctrl_q;

    dds_cmd_classify u_classify (
        .valid_i (cmd_valid),
        .word_i  (cmd_word),
        .cmd_o   (cmd)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (cmd.vld && cmd.tgt == TGT_CTRL) ctrl_d = cmd.ctrl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    dds_freq_loader u_freq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .paired_i (ctrl_q[CB_PAIRED]),
        .msb_i    (ctrl_q[CB_MSB]),
        .freq0_o  (freq0),
        .freq1_o  (freq1)
    );

    dds_phase_bank u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .phase0_o (phase0),
        .phase1_o (phase1)
    );

    assign ctrl_word = ctrl_q;
    assign freq_sel  = ctrl_q[CB_FSEL];
    assign phase_sel = ctrl_q[CB_PSEL];

    AST_SELECTS_FOLLOW_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[15:14] == 2'b00)
        |=> (freq_sel == $past(cmd_word[11]) && phase_sel == $past(cmd_word[10]))); // R2

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(ctrl_word) && $stable(freq0) && $stable(freq1)
                        && $stable(phase0) && $stable(phase1))); // R11

endmodule

// File: tb/dds_reg_decoder_tb_top.sv
`timescale 1ns/1ps
module dds_reg_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [13:0] ctrl_word;
    logic [27:0] freq0, freq1;
    logic [11:0] phase0, phase1;
    logic        freq_sel, phase_sel;

    always #4 clk = ~clk;

    dds_reg_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .ctrl_word(ctrl_word), .freq0(freq0), .freq1(freq1),
        .phase0(phase0), .phase1(phase1), .freq_sel(freq_sel), .phase_sel(phase_sel)
    );

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [95:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    // bench reference state
    logic [13:0] m_ctrl = '0;
    logic [27:0] m_f0 = '0, m_f1 = '0;
    logic [11:0] m_p0 = '0, m_p1 = '0;
    logic [13:0] m_stage = '0;
    logic        m_pend = 1'b0;
    logic        m_pidx = 1'b0;

    function automatic logic [95:0] snap_exp();
        return {m_ctrl, m_f0, m_f1, m_p0, m_p1, m_ctrl[11], m_ctrl[10]};
    endfunction

    function automatic logic [95:0] snap_act();
        return {ctrl_word, freq0, freq1, phase0, phase1, freq_sel, phase_sel};
    endfunction

    task automatic check(input logic [95:0] act, input logic [95:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_apply(input logic [15:0] w);
        logic idx;
        idx = w[15];
        case (w[15:14])
            2'b00: begin m_ctrl = w[13:0]; m_pend = 1'b0; end
            2'b11: begin
                if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
                m_pend = 1'b0;
            end
            default: begin
                if (m_ctrl[13]) begin
                    if (m_pend && m_pidx == idx) begin
                        if (idx) m_f1 = {w[13:0], m_stage}; else m_f0 = {w[13:0], m_stage};
                        m_pend = 1'b0;
                    end else begin
                        m_stage = w[13:0]; m_pend = 1'b1; m_pidx = idx;
                    end
                end else begin
                    m_pend = 1'b0;
                    if (m_ctrl[12]) begin
                        if (idx) m_f1[27:14] = w[13:0]; else m_f0[27:14] = w[13:0];
                    end else begin
                        if (idx) m_f1[13:0] = w[13:0]; else m_f0[13:0] = w[13:0];
                    end
                end
            end
        endcase
    endtask

    // driver: one strobed word; expectation queued for the monitor
    task automatic send(input logic [15:0] w, input string tag);
        item_t it;
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = 1'b1;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        model_apply(w);
        it.exp = snap_exp();
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // word held without strobe: outputs must not move (R11)
    task automatic idle(input logic [15:0] w, input string tag);
        item_t it;
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = 1'b0;
        @(posedge clk);
        #1;
        it.exp = snap_exp();
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(snap_act(), it.exp, it.tag);
            end
        end
    end

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic direct(input logic [27:0] act, input logic [27:0] exp, input string tag);
        check({68'd0, act}, {68'd0, exp}, tag);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(snap_act(), 96'd0, "R1 reset state");

        // paired load example
        send(16'h2000, "R2 ctrl paired");
        send(16'h4000, "R6 first half no commit");
        drain();
        direct(freq0, 28'h0, "R6 freq0 untouched by first half");
        send(16'h403F, "R5 paired commit");
        drain();
        direct(freq0, 28'h00FC000, "R5 freq0 paired example");

        // split low half into freq1 with non-zero high half
        send(16'h1000, "R2 ctrl msb split");
        send(16'h8123, "R8 freq1 high half");
        send(16'h0000, "R2 ctrl lsb split");
        send(16'hBFFF, "R7 freq1 low half");
        drain();
        direct(freq1, {14'h0123, 14'h3FFF}, "R7 freq1 low written high kept");

        // split high half example into freq0
        send(16'h0000, "R2 ctrl");
        send(16'h4011, "R4 freq0 low half");
        send(16'h1000, "R2 ctrl msb");
        send(16'h40FF, "R8 freq0 high half");
        drain();
        direct(freq0, {14'h00FF, 14'h0011}, "R8 freq0 high written low kept");

        // phase registers, bit 12 ignored
        send(16'hC123, "R3 phase0");
        send(16'hF456, "R3 phase1 bit12 ignored");
        drain();
        direct({16'h0, phase1}, {16'h0, 12'h456}, "R3 phase1 value");
        direct({16'h0, phase0}, {16'h0, 12'h123}, "R3 phase0 kept");

        // select outputs
        send(16'h0C00, "R2 both selects");
        send(16'h0800, "R2 freq select only");
        send(16'h0400, "R2 phase select only");

        // cancel by control word
        send(16'h2000, "R2 ctrl paired");
        send(16'h4AAA, "R9 staged half");
        send(16'h2000, "R9 ctrl cancels");
        send(16'h4022, "R9 new low half");
        send(16'h4033, "R9 commit");
        drain();
        direct(freq0, {14'h0033, 14'h0022}, "R9 freq0 after ctrl cancel");

        // cancel by phase word
        send(16'h8011, "R9 staged half f1");
        send(16'hC000, "R9 phase cancels");
        send(16'h8022, "R9 new low half f1");
        send(16'h8033, "R9 commit f1");
        drain();
        direct(freq1, {14'h0033, 14'h0022}, "R9 freq1 after phase cancel");

        // other address between halves
        send(16'h4005, "R10 f0 staged");
        send(16'h8006, "R10 f1 takes over staging");
        send(16'h4007, "R10 f0 restages");
        send(16'h4008, "R10 f0 commit");
        drain();
        direct(freq0, {14'h0008, 14'h0007}, "R10 freq0 pair");
        direct(freq1, {14'h0033, 14'h0022}, "R10 freq1 untouched");

        // strobe low
        idle(16'h4FFF, "R11 idle freq word");
        idle(16'h0FFF, "R11 idle ctrl word");
        idle(16'hDFFF, "R11 idle phase word");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule